// File: doc/BRIEF.md
# Parallel Ramp-Compare Conversion Controller

This block is the digital half of a bank of ramp-compare converters that turns a whole group of stored analog samples into codes in a single pass. After a start pulse it clears every lane and runs one shared counter, counting in Gray code, while an external ramp is taken to be rising. Each lane watches its own comparator. The first time that comparator goes high, the lane stores the count present at that moment. The stored count is therefore a measure of when the ramp crossed the sample voltage.

A pass ends in one of two ways: every lane has captured a count, or the counter has reached its last value. Any lane whose comparator never fired is then given the full-scale code and an overflow flag. A readout port takes a lane index and returns that lane's result one cycle later, converted from Gray code to binary. With the defaults there are 64 lanes and 12-bit results. An idle input typically reads near 2000, with a few hundred counts of spread between cells.

Top module: `ramp_adc_bank`

## Requirements
- R1: While reset is held and right after it, `done`, `rdData` and `rdOvf` are all zero.
- R2: A start pulse clears the counter and every lane's code and overflow flag, and drops `done`. Reading any lane after a start and before it captures returns code 0 with `rdOvf` low.
- R3: Take the clock edge that samples `start` as edge 0. If a lane's comparator input rises between edge k and edge k+1, that lane reports the binary value k+2. This is the count present when the edge emerges from the two-flop synchronizer. The shared count changes in only one bit per cycle.
- R4: Only the first rising edge of a comparator within a pass is captured. Later falls and rises on that lane leave its code unchanged.
- R5: A lane that has captured nothing when the pass ends reports 4095 with `rdOvf` = 1. A lane that captured reports `rdOvf` = 0.
- R6: A lane whose capture falls on the final count (k+2 = 4095) reports 4095 with `rdOvf` = 0.
- R7: When every lane has captured before the last count, `done` rises one cycle after the last capture, at edge kmax+4, where kmax is the latest k of any lane.
- R8: When some lane is still waiting at the last count, `done` rises at edge 4096, one cycle after the counter reaches 4095.
- R9: `rdData` and `rdOvf` show, in binary, the result for the `rdIdx` value sampled at the previous clock edge.
- R10: `done` stays high until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a pass |
| comp | input | 64 | Comparator outputs, one per lane, asynchronous |
| done | output | 1 | High once the pass has ended |
| rdIdx | input | 6 | Lane to read |
| rdData | output | 12 | Binary result of the lane that was read |
| rdOvf | output | 1 | Overflow flag of the lane that was read |

## Verification
The embedded assertions check, on every cycle, the following:
- the shared count moves by at most one bit;
- start zeroes the count and drops `done`;
- a captured lane code never changes until the next start;
- `done` holds;
- `done` only rises after either the last count or a full set of captures.

Only the bench scenarios can show the rest. These are that the reported value is exactly the synchronized crossing count, that uncaptured lanes turn into 4095 with the flag set, that the final count is taken as a real capture, the exact edges on which `done` rises, and that readout is binary with one cycle of latency.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clearAll; // start of pass: wipe lanes
    logic capEn;    // counter running, captures allowed
    logic finish;   // pass ends this edge: mark unfired lanes
  } adcStrobe_t;
endpackage

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             allFired,
  output adcStrobe_t       strobe,
  output logic [CNT_W-1:0] grayCnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctlState_t;
  ctlState_t state;
  logic [CNT_W-1:0] binCnt;
  logic [CNT_W-1:0] nxtBin;
  logic termHit;

  assign nxtBin  = binCnt + 1'b1;
  assign termHit = (state == ST_RUN) && ((binCnt == CNT_MAX) || allFired);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      binCnt  <= '0;
      grayCnt <= '0;
    end else if (start) begin
      state   <= ST_RUN;
      binCnt  <= '0;
      grayCnt <= '0;
    end else if (state == ST_RUN) begin
      if (termHit) begin
        state <= ST_DONE;
      end else begin
        binCnt  <= nxtBin;
        grayCnt <= nxtBin ^ (nxtBin >> 1);
      end
    end
  end

  always_comb begin
    strobe.clearAll = start;
    strobe.capEn    = (state == ST_RUN) && !start;
    strobe.finish   = termHit && !start;
  end

  assign done = (state == ST_DONE);

  // shared count never moves more than one bit, bounding capture error
  assert_gray_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($countones(grayCnt ^ $past(grayCnt)) <= 1));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (grayCnt == '0 && !done));

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(binCnt) == CNT_MAX || $past(allFired)));
endmodule

// File: rtl/ramp_adc_datapath.sv
module ramp_adc_datapath
  import ramp_adc_pkg::*;
#(
  parameter int LANES = 64,
  parameter int CNT_W = 12,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  adcStrobe_t       strobe,
  input  logic [CNT_W-1:0] grayCnt,
  input  logic [LANES-1:0] comp,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             allFired,
  output logic [CNT_W-1:0] rdData,
  output logic             rdOvf
);
  // Gray code of the all-ones binary value
  localparam logic [CNT_W-1:0] FULL_GRAY = {1'b1, {(CNT_W-1){1'b0}}};

  logic [LANES-1:0] syncA, syncB, prevB;
  logic [CNT_W-1:0] laneCode [LANES];
  logic             laneFired [LANES];
  logic             laneOvf [LANES];

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int k = CNT_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= comp;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic rise;
    assign rise = syncB[i] && !prevB[i];

    always_ff @(posedge clk) begin
      if (!rst_n || strobe.clearAll) begin
        laneCode[i]  <= '0;
        laneFired[i] <= 1'b0;
        laneOvf[i]   <= 1'b0;
      end else if (strobe.capEn && rise && !laneFired[i]) begin
        laneCode[i]  <= grayCnt;
        laneFired[i] <= 1'b1;
      end else if (strobe.finish && !laneFired[i]) begin
        laneCode[i] <= FULL_GRAY;
        laneOvf[i]  <= 1'b1;
      end
    end

    assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (laneFired[i] && !strobe.clearAll) |=> $stable(laneCode[i]));
  end

  always_comb begin
    allFired = 1'b1;
    for (int i = 0; i < LANES; i++) allFired = allFired & laneFired[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
      rdOvf  <= 1'b0;
    end else begin
      rdData <= grayToBin(laneCode[rdIdx]);
      rdOvf  <= laneOvf[rdIdx];
    end
  end
endmodule

// File: rtl/ramp_adc_bank.sv
module ramp_adc_bank
  import ramp_adc_pkg::*;
#(
  parameter int LANES = 64,
  parameter int CNT_W = 12,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LANES-1:0] comp,
  output logic             done,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] rdData,
  output logic             rdOvf
);
  adcStrobe_t       strobe;
  logic [CNT_W-1:0] grayCnt;
  logic             allFired;

  ramp_adc_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .allFired(allFired),
    .strobe(strobe), .grayCnt(grayCnt), .done(done)
  );

  ramp_adc_datapath #(.LANES(LANES), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .grayCnt(grayCnt),
    .comp(comp), .rdIdx(rdIdx), .allFired(allFired),
    .rdData(rdData), .rdOvf(rdOvf)
  );
endmodule

// File: tb/test_ramp_adc_bank.sv
module test_ramp_adc_bank;
  localparam int LANES = 64;
  localparam int FULL  = 4095;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] comp = '0;
  logic        done;
  logic [5:0]  rdIdx = '0;
  logic [11:0] rdData;
  logic        rdOvf;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int fireT [LANES];
  bit glitch [LANES];

  typedef struct {
    int    lane;
    int    expVal;
    bit    expOvf;
    string tag;
  } readItem_t;
  readItem_t sbQ[$];

  ramp_adc_bank i_ramp_adc_bank (
    .clk(clk), .rst_n(rst_n), .start(start), .comp(comp), .done(done),
    .rdIdx(rdIdx), .rdData(rdData), .rdOvf(rdOvf)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: one pop per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        readItem_t it;
        it = sbQ.pop_front();
        check({it.tag, " data"}, rdData == 12'(it.expVal), int'(rdData), it.expVal);
        check({it.tag, " ovf"}, rdOvf == it.expOvf, int'(rdOvf), int'(it.expOvf));
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  function automatic int expectedDone();
    int mx = 0;
    for (int i = 0; i < LANES; i++) begin
      if (fireT[i] < 0 || fireT[i] + 2 > FULL) return FULL + 1;
      if (fireT[i] > mx) mx = fireT[i];
    end
    return (mx + 4 < FULL + 1) ? mx + 4 : FULL + 1;
  endfunction

  task automatic runConv(input string doneTag, input bit checkClear);
    int doneT = -1;
    int expT;
    expT = expectedDone();
    rdIdx = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int t = 0; t < 5000; t++) begin
      if (t == 0) check("R2 done cleared", done == 1'b0, int'(done), 0);
      if (t == 1 && checkClear) begin
        check("R2 lane code cleared", rdData == 12'd0, int'(rdData), 0);
        check("R2 lane ovf cleared", rdOvf == 1'b0, int'(rdOvf), 0);
      end
      if (done && doneT < 0) doneT = t;
      if (doneT >= 0) break;
      for (int i = 0; i < LANES; i++) begin
        bit hi;
        hi = (fireT[i] >= 0) && (t >= fireT[i]);
        if (glitch[i] && t >= fireT[i] + 4 && t < fireT[i] + 10) hi = 0;
        comp[i] = hi;
      end
      @(negedge clk);
    end
    check(doneTag, doneT == expT, doneT, expT);
    comp = '0;
    repeat (3) @(negedge clk);
    check("R10 done held", done == 1'b1, int'(done), 1);
  endtask

  task automatic readAll(input string baseTag);
    for (int i = 0; i < LANES; i++) begin
      readItem_t it;
      @(negedge clk);
      rdIdx = 6'(i);
      it.lane = i;
      if (fireT[i] < 0 || fireT[i] + 2 > FULL) begin
        it.expVal = FULL; it.expOvf = 1; it.tag = "R5 unfired lane";
      end else begin
        it.expVal = fireT[i] + 2; it.expOvf = 0;
        it.tag = (fireT[i] + 2 == FULL) ? "R6 last count" :
                 glitch[i] ? "R4 first edge only" : baseTag;
      end
      sbQ.push_back(it);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done reset", done == 1'b0, int'(done), 0);
    check("R1 data reset", rdData == 12'd0, int'(rdData), 0);
    check("R1 ovf reset", rdOvf == 1'b0, int'(rdOvf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", done == 1'b0, int'(done), 0);

    // pass A: all lanes fire around 2000, one lane bounces
    for (int i = 0; i < LANES; i++) begin
      fireT[i] = 1900 + (i * 53) % 250;
      glitch[i] = (i == 5);
    end
    runConv("R7 done after all fired", 0);
    readAll("R3,R9 capture value");

    // pass B: missing lane, last-count lane, too-late lane, early lane
    for (int i = 0; i < LANES; i++) begin
      fireT[i] = 10 + (i * 61) % 4000;
      glitch[i] = 0;
    end
    fireT[7] = -1;
    fireT[8] = FULL - 2;
    fireT[9] = FULL - 1;
    fireT[10] = 0;
    runConv("R8 done at terminal count", 1);
    readAll("R3,R9 capture value");

    // pass C: tight group, start must wipe previous results
    for (int i = 0; i < LANES; i++) begin
      fireT[i] = 100 + i % 3;
      glitch[i] = (i == 20);
    end
    runConv("R7 done after all fired", 1);
    readAll("R3,R9 capture value");

    finishRun();
  end
endmodule